// File: doc/BRIEF.md
# Cascaded Up/Down Timer Pair with Capture Buffering

This block joins two W-bit counters in cascade. The low counter steps when `cnt_en` is high. It counts up or down as `cnt_down` selects. Each time it wraps, the high counter takes one step in the same direction. The high counter owns a compare register. The low channel owns a capture register with a buffer register behind it. The high channel owns a second capture register that records the high count on every capture event. Sticky flags report compare matches and captures.

A CPU writes the counters and registers over a two-phase synchronous bus. In the address phase, `bus_sel` is high and `bus_addr` is valid. In the next cycle, the data phase, `bus_wdata` is valid. The block settles same-cycle conflicts between a data-phase write and the hardware events with fixed priorities:

- A write to the low counter wins over that counter's wrap, and the high counter does not step.
- A capture wins over a write to the capture registers or the buffer.
- Events that hang on the raw wrap (compare match, capture sourced from the wrap, cascade clear) still fire on such a cycle.

Top module: `casc_timer`

## Requirements
- R1: A write presented with `bus_sel`=1 and `bus_addr` in one cycle takes `bus_wdata` in the following cycle and updates the register at the end of that data-phase cycle. The address map is: 0 low counter, 1 high counter, 2 high compare, 3 capture A, 4 buffer, 5 capture B, 6 control (bit0 capture source, bit1 clear on match), 7 flag clear.
- R2: With `cnt_en`=1, the low counter adds 1 when `cnt_down`=0 and subtracts 1 when `cnt_down`=1. Up mode wraps from all-ones to zero with a carry. Down mode wraps from zero to all-ones with a borrow.
- R3: On a carry the high counter adds 1, and on a borrow it subtracts 1. Otherwise it holds, unless it is written or cleared.
- R4: A data-phase write to the low counter in a wrap cycle loads the written value, and the high counter does not step.
- R5: A compare-match event occurs in every wrap cycle, suppressed or not, in which the high counter already equals the compare register. It sets `flags[0]`.
- R6: On a capture event, capture A takes the low count, the buffer takes the old capture A, capture B takes the high count, and `flags[1]` is set, all in one clock. The event is `cap_in` when control bit0 is 0, and the raw low wrap (including a suppressed one) when it is 1.
- R7: A capture event discards a data-phase write to capture A, the buffer or capture B in the same cycle.
- R8: With control bit1 set, a compare-match event clears both counters in the same cycle. A data-phase write to a counter in that cycle wins over the clear for that counter.
- R9: Flags are sticky. Writing 1 to a bit at address 7 clears that bit, and a new event in the same cycle keeps it set.
- R10: While `rst_n` is low, all registers, flags and the bus phase are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Low counter count enable |
| cnt_down | input | 1 | 1 = count down, 0 = count up |
| cap_in | input | 1 | External capture strobe |
| bus_sel | input | 1 | Address-phase write strobe |
| bus_addr | input | AW | Register address (address phase) |
| bus_wdata | input | W | Write data (data phase) |
| lo_count | output | W | Low counter |
| hi_count | output | W | High counter |
| cap_a | output | W | Low channel capture register |
| cap_buf | output | W | Buffer behind capture A |
| cap_b | output | W | High channel capture register |
| flags | output | 2 | bit0 compare match, bit1 capture |

## Verification
The assertions take for granted that `bus_wdata` carries the write data in the cycle after `bus_sel`. They also assume that `cap_in` and `cnt_en` are sampled plainly on each edge, with no synchronisation expected of the block.

The stimulus keeps to this convention. It presents data only in the data phase of each write, and it drives every input at the falling edge. Conflicts are forced by placing a write's data phase on the exact wrap or capture cycle. A long random phase then lets writes, wraps and captures meet freely against the reference model.

// File: rtl/casc_timer.sv
module casc_timer #(
  parameter int W  = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          cnt_down,
  input  logic          cap_in,
  input  logic          bus_sel,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  lo_count,
  output logic [W-1:0]  hi_count,
  output logic [W-1:0]  cap_a,
  output logic [W-1:0]  cap_buf,
  output logic [W-1:0]  cap_b,
  output logic [1:0]    flags
);
  localparam logic [W-1:0] TOP = '1;

  logic          ph_valid;
  logic [AW-1:0] ph_addr;
  logic [W-1:0]  cmp_hi;
  logic [1:0]    ctrl;

  logic wr_lo, wr_hi, wr_cmp, wr_ca, wr_buf, wr_cb, wr_ctl, wr_flg;
  logic wrap, match_evt, cap_evt, clr;

  assign wr_lo  = ph_valid && ph_addr == AW'(0);
  assign wr_hi  = ph_valid && ph_addr == AW'(1);
  assign wr_cmp = ph_valid && ph_addr == AW'(2);
  assign wr_ca  = ph_valid && ph_addr == AW'(3);
  assign wr_buf = ph_valid && ph_addr == AW'(4);
  assign wr_cb  = ph_valid && ph_addr == AW'(5);
  assign wr_ctl = ph_valid && ph_addr == AW'(6);
  assign wr_flg = ph_valid && ph_addr == AW'(7);

  assign wrap      = cnt_en && (cnt_down ? lo_count == '0 : lo_count == TOP);
  assign match_evt = wrap && hi_count == cmp_hi;
  assign cap_evt   = ctrl[0] ? wrap : cap_in;
  assign clr       = match_evt && ctrl[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_valid <= 1'b0;
      ph_addr  <= '0;
    end else begin
      ph_valid <= bus_sel;
      ph_addr  <= bus_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        lo_count <= '0;
    else if (wr_lo)    lo_count <= bus_wdata;
    else if (clr)      lo_count <= '0;
    else if (cnt_en)   lo_count <= cnt_down ? lo_count - 1'b1 : lo_count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              hi_count <= '0;
    else if (wr_hi)          hi_count <= bus_wdata;
    else if (clr)            hi_count <= '0;
    else if (wrap && !wr_lo) hi_count <= cnt_down ? hi_count - 1'b1 : hi_count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_hi <= '0;
      ctrl   <= '0;
    end else begin
      if (wr_cmp) cmp_hi <= bus_wdata;
      if (wr_ctl) ctrl   <= bus_wdata[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_a   <= '0;
      cap_buf <= '0;
      cap_b   <= '0;
    end else if (cap_evt) begin
      cap_a   <= lo_count;
      cap_buf <= cap_a;
      cap_b   <= hi_count;
    end else begin
      if (wr_ca)  cap_a   <= bus_wdata;
      if (wr_buf) cap_buf <= bus_wdata;
      if (wr_cb)  cap_b   <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else flags <= (flags & ~(wr_flg ? bus_wdata[1:0] : 2'b00)) | {cap_evt, match_evt};
  end

  AST_WR_LO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo && wrap |=> lo_count == $past(bus_wdata)); // R4
  AST_NO_HI_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo && wrap && !wr_hi && !clr |=> hi_count == $past(hi_count)); // R4
  AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> flags[0]); // R5
  AST_CAP_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_buf == $past(cap_a) && cap_a == $past(lo_count) && flags[1]); // R6
  AST_CAP_BEATS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt && wr_buf |=> cap_buf == $past(cap_a)); // R7
  AST_CLR_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !wr_lo && !wr_hi |=> lo_count == '0 && hi_count == '0); // R8
endmodule

// File: tb/tb_casc_timer.sv
module tb_casc_timer;
  localparam int W = 16;
  logic clk = 0, rst_n = 0;
  logic cnt_en = 0, cnt_down = 0, cap_in = 0, bus_sel = 0;
  logic [2:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] lo_count, hi_count, cap_a, cap_buf, cap_b;
  logic [1:0]  flags;
  int vectors = 0, errors = 0;

  casc_timer #(.W(W), .AW(3)) dut (.*);

  always #10 clk = ~clk;

  int m_lo, m_hi, m_cmp, m_ca, m_buf, m_cb, m_ctl, m_flg, m_ph, m_pa;
  always @(posedge clk) begin
    int n_lo, n_hi, wd, wp, mt, ce, cl;
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_cmp = 0; m_ca = 0; m_buf = 0; m_cb = 0;
      m_ctl = 0; m_flg = 0; m_ph = 0; m_pa = 0;
    end else begin
      wd = bus_wdata;
      wp = cnt_en && (cnt_down ? m_lo == 0 : m_lo == 65535);
      mt = wp && (m_hi == m_cmp);
      ce = (m_ctl % 2) ? wp : cap_in;
      cl = mt && (m_ctl / 2);
      n_lo = m_lo; n_hi = m_hi;
      if (m_ph && m_pa == 0) n_lo = wd;
      else if (cl) n_lo = 0;
      else if (cnt_en) n_lo = (m_lo + (cnt_down ? 65535 : 1)) % 65536;
      if (m_ph && m_pa == 1) n_hi = wd;
      else if (cl) n_hi = 0;
      else if (wp && !(m_ph && m_pa == 0)) n_hi = (m_hi + (cnt_down ? 65535 : 1)) % 65536;
      if (m_ph && m_pa == 2) m_cmp = wd;
      if (m_ph && m_pa == 6) m_ctl = wd % 4;
      if (ce) begin
        m_buf = m_ca; m_ca = m_lo; m_cb = m_hi;
      end else begin
        if (m_ph && m_pa == 3) m_ca = wd;
        if (m_ph && m_pa == 4) m_buf = wd;
        if (m_ph && m_pa == 5) m_cb = wd;
      end
      if (m_ph && m_pa == 7) m_flg = m_flg & ~(wd % 4);
      m_flg = m_flg | (ce ? 2 : 0) | (mt ? 1 : 0);
      m_lo = n_lo; m_hi = n_hi;
      m_ph = bus_sel; m_pa = bus_addr;
    end
  end

  task automatic cmp1(string tag, string nm, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, nm, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    cmp1(tag, "lo_count", lo_count, m_lo);
    cmp1(tag, "hi_count", hi_count, m_hi);
    cmp1(tag, "cap_a", cap_a, m_ca);
    cmp1(tag, "cap_buf", cap_buf, m_buf);
    cmp1(tag, "cap_b", cap_b, m_cb);
    cmp1(tag, "flags", flags, m_flg);
  endtask

  // one clock: drive at negedge, check after the following posedge
  task automatic cyc(string tag, bit sel, int adr, int wd, bit en, bit dn, bit cp);
    bus_sel = sel; bus_addr = 3'(adr); bus_wdata = 16'(wd);
    cnt_en = en; cnt_down = dn; cap_in = cp;
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic wr(string tag, int adr, int wd);
    cyc(tag, 1, adr, 0, 0, 0, 0);
    cyc(tag, 0, 0, wd, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check_all("R10");
    rst_n = 1;
    cmp1("R10", "lo_count reset", lo_count, 0);
    wr("R1", 2, 1);
    wr("R1", 0, 16'hFFFE);
    cmp1("R1", "lo after write", lo_count, 16'hFFFE);
    for (int i = 0; i < 3; i++) cyc("R2 R3 up", 0, 0, 0, 1, 0, 0);
    cmp1("R3", "hi after carry", hi_count, 1);
    // R5: wrap with hi==cmp
    wr("R4", 0, 16'hFFFF);
    cyc("R4", 1, 0, 0, 0, 0, 0);
    cyc("R4 R5", 0, 0, 16'h1234, 1, 0, 0);
    cmp1("R4", "lo loaded", lo_count, 16'h1234);
    cmp1("R4", "hi held", hi_count, 1);
    cmp1("R5", "match flag", flags[0], 1);
    wr("R2", 0, 0);
    cyc("R2 R3 down", 0, 0, 0, 1, 1, 0);
    cmp1("R3", "hi after borrow", hi_count, 0);
    cmp1("R2", "lo after borrow", lo_count, 16'hFFFF);
    cyc("R6", 0, 0, 0, 0, 0, 1);
    cyc("R6", 0, 0, 0, 1, 0, 0);
    cyc("R6", 0, 0, 0, 0, 0, 1);
    cmp1("R6", "buffer", cap_buf, 16'hFFFF);
    cyc("R7", 1, 4, 0, 0, 0, 0);
    cyc("R7", 0, 0, 16'hBEEF, 0, 0, 1);
    cmp1("R7", "buffer not written", cap_buf, 16'h0000);
    wr("R9", 7, 3);
    cmp1("R9", "flags cleared", flags, 0);
    cyc("R9", 1, 7, 0, 0, 0, 0);
    cyc("R9", 0, 0, 3, 0, 0, 1);
    cmp1("R9", "event wins clear", flags, 2);
    wr("R6", 6, 1);
    wr("R6", 0, 16'hFFFF);
    cyc("R6", 1, 0, 0, 0, 0, 0);
    cyc("R6 R4", 0, 0, 16'h0055, 1, 0, 0);
    cmp1("R6", "cap on suppressed wrap", cap_a, 16'hFFFF);
    wr("R8", 6, 2);
    wr("R8", 2, 5);
    wr("R8", 1, 5);
    wr("R8", 0, 16'hFFFF);
    cyc("R8", 0, 0, 0, 1, 0, 0);
    cmp1("R8", "lo cleared", lo_count, 0);
    cmp1("R8", "hi cleared", hi_count, 0);
    for (int i = 0; i < 4000; i++) begin
      int a;
      a = $urandom_range(0, 15);
      cyc("random R4 R7 R8", $urandom_range(0, 1), a % 8,
          (a > 11) ? 16'hFFFF : ((a > 9) ? 0 : $urandom_range(0, 65535)),
          $urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 3) == 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule